// File: doc/BRIEF.md
# Calibration Pulse and Reverse-Power Flag Generator

This block turns a stream of signed real-power samples into a fast calibration pulse train and a flag that reports the sign of the power. Each accepted sample adds its magnitude to a private energy accumulator. When the accumulator reaches a threshold, one calibration pulse starts and the threshold is taken off the accumulator. The threshold is the slow-output threshold (2^BASE_LOG2) divided by a rate multiplier, and three mode pins pick that multiplier. The reverse-power flag is loaded with the sign of the sample that fired the pulse. It holds that value until the next pulse.

In the ordinary modes the pulse width is counted in ticks of a coarse timebase. The pulse is NOM_TICKS wide, but it shrinks to half of the previous pulse-to-pulse interval when that interval is shorter than 2*NOM_TICKS. In the fast mode the width is a fixed HF_CYCLES clock cycles. Samples whose magnitude is below a no-load floor are discarded. While the supply-valid input is low, the block is held inactive.

A pulse event that arrives while a pulse is still high restarts the width count, so the output stays high. A single sample fires at most one pulse.

Top module: `cal_pulse_gen`

## Requirements
- R1: The mode {cal_range, rate_hi, rate_lo} sets the rate shift as follows: 100 gives 7, 000 and 101 give 6, 001 and 110 give 5, 010 and 111 give 4, and 011 gives 11. The pulse threshold is 2^BASE_LOG2 shifted right by that amount.
- R2: Each accepted sample adds |sample| to the accumulator. A pulse fires on the sample that brings the sum to the threshold or above, and the excess (sum minus threshold) stays in the accumulator.
- R3: The excess kept after a pulse is limited to the threshold minus one.
- R4: A sample whose magnitude is below NOLOAD_MIN is discarded. It changes neither the accumulator nor the outputs.
- R5: cal_pulse goes high in the clock cycle after the firing sample is presented.
- R6: In the ordinary modes, a pulse lasts NOM_TICKS ticks when it is the first pulse since reset or power-up. It also lasts NOM_TICKS ticks when at least 2*NOM_TICKS ticks passed since the previous pulse started.
- R7: In the ordinary modes, when fewer than 2*NOM_TICKS ticks (P ticks) passed since the previous pulse started, the pulse lasts max(1, P/2) ticks, with P/2 rounded down.
- R8: In mode 011, a pulse lasts exactly HF_CYCLES clock cycles, independent of ticks.
- R9: rev_flag becomes 1 for a negative firing sample and 0 for a non-negative one. It updates in the same cycle cal_pulse rises, and at no other time except power loss.
- R10: While supply_ok is low, cal_pulse is 0 from the next cycle on and samples are ignored. The accumulator, the interval history and rev_flag are cleared.
- R11: After reset, cal_pulse and rev_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-valid flag; low holds the block inactive |
| tick | input | 1 | One-cycle strobe of the coarse width timebase |
| sample_valid | input | 1 | A power sample is present this cycle |
| sample | input | SAMPLE_W | Signed real-power sample |
| cal_range | input | 1 | Mode bit 2 (calibration range select) |
| rate_hi | input | 1 | Mode bit 1 |
| rate_lo | input | 1 | Mode bit 0 |
| cal_pulse | output | 1 | Calibration pulse, active high |
| rev_flag | output | 1 | High while the last pulse came from negative power |

## Verification
The hardest condition to reach from the ports is a width that depends on the previous interval. It needs two pulses in a row with a controlled number of ticks between them. The bench sets this up with a large sample that fires on every sample in a 64x mode, then issues a chosen number of ticks after each one. It then measures, tick by tick, when the pulse falls.

The remainder limit is only visible indirectly. The bench fires in the fast mode with an oversized sample, switches to a 128x mode, and counts the small samples needed for the next pulse.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

  // Right shift applied to the slow-output threshold for each mode code.
  function automatic logic [3:0] rate_shift(input logic [2:0] mode);
    case (mode)
      3'b100:          return 4'd7;
      3'b000, 3'b101:  return 4'd6;
      3'b001, 3'b110:  return 4'd5;
      3'b010, 3'b111:  return 4'd4;
      default:         return 4'd11;
    endcase
  endfunction

  // Fast mode: fixed width counted in clock cycles.
  function automatic logic is_fast(input logic [2:0] mode);
    return mode == 3'b011;
  endfunction

  // Width in ticks, from the interval since the previous pulse.
  function automatic int width_from_period(input int per, input int nom);
    if (per >= 2 * nom) return nom;
    if (per / 2 == 0)   return 1;
    return per / 2;
  endfunction

endpackage

// File: rtl/cfa_accum.sv
module cfa_accum #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_LOG2  = 20,
  parameter int NOLOAD_MIN = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [3:0]                 shift,
  output logic                       fire,
  output logic                       fire_neg,
  output logic                       light,
  output logic [BASE_LOG2-1:0]       acc_level,
  output logic [BASE_LOG2:0]         thr
);
  localparam int MAG_W = SAMPLE_W + 1;
  localparam int SUM_W = ((BASE_LOG2 > MAG_W) ? BASE_LOG2 : MAG_W) + 1;

  logic signed [MAG_W-1:0] sx;
  logic [MAG_W-1:0]        mag;
  logic [SUM_W-1:0]        sum, thr_x, rem, kept;
  logic [BASE_LOG2-1:0]    acc_q;

  always_comb begin
    sx    = MAG_W'(sample);
    mag   = (sx < 0) ? MAG_W'(-sx) : MAG_W'(sx);
    thr   = {1'b1, {BASE_LOG2{1'b0}}} >> shift;
    thr_x = SUM_W'(thr);
    sum   = SUM_W'(acc_q) + SUM_W'(mag);
    light = mag < MAG_W'(NOLOAD_MIN);
    fire  = valid && !clear && !light && (sum >= thr_x);
    rem   = sum - thr_x;
    kept  = (rem >= thr_x) ? thr_x - SUM_W'(1) : rem;
    fire_neg = sample[SAMPLE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_q <= '0;
    else if (clear)              acc_q <= '0;
    else if (valid && !light)    acc_q <= fire ? kept[BASE_LOG2-1:0] : sum[BASE_LOG2-1:0];
  end

  assign acc_level = acc_q;
endmodule

// File: rtl/cfa_shaper.sv
module cfa_shaper #(
  parameter int NOM_TICKS = 9,
  parameter int HF_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic fire,
  input  logic fire_neg,
  input  logic fast_mode,
  output logic pulse,
  output logic rev,
  output logic hf_active
);
  import cfa_pkg::*;

  localparam int SAT  = 2 * NOM_TICKS;
  localparam int PER_W = $clog2(SAT + 1);
  localparam int WL_W  = $clog2(NOM_TICKS + 1);
  localparam int HC_W  = $clog2(HF_CYCLES + 1);

  logic             pulse_q, rev_q, fast_q;
  logic [PER_W-1:0] per_cnt;
  logic [WL_W-1:0]  wlen, wcnt;
  logic [HC_W-1:0]  hcnt;
  logic             tick_done, cyc_done;

  assign tick_done = ({1'b0, wcnt} + 1'b1) >= {1'b0, wlen};
  assign cyc_done  = ({1'b0, hcnt} + 1'b1) >= (HC_W + 1)'(HF_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0; rev_q <= 1'b0; fast_q <= 1'b0;
      per_cnt <= PER_W'(SAT); wlen <= '0; wcnt <= '0; hcnt <= '0;
    end else if (clear) begin
      pulse_q <= 1'b0; rev_q <= 1'b0; fast_q <= 1'b0;
      per_cnt <= PER_W'(SAT); wlen <= '0; wcnt <= '0; hcnt <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      rev_q   <= fire_neg;
      fast_q  <= fast_mode;
      wlen    <= WL_W'(width_from_period(int'(per_cnt), NOM_TICKS));
      wcnt    <= '0;
      hcnt    <= '0;
      per_cnt <= '0;
    end else begin
      if (tick && per_cnt < PER_W'(SAT)) per_cnt <= per_cnt + 1'b1;
      if (pulse_q) begin
        if (fast_q) begin
          if (cyc_done) pulse_q <= 1'b0;
          else          hcnt    <= hcnt + 1'b1;
        end else if (tick) begin
          if (tick_done) pulse_q <= 1'b0;
          else           wcnt    <= wcnt + 1'b1;
        end
      end
    end
  end

  assign pulse     = pulse_q;
  assign rev       = rev_q;
  assign hf_active = fast_q;
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_LOG2  = 20,
  parameter int NOLOAD_MIN = 16,
  parameter int NOM_TICKS  = 9,
  parameter int HF_CYCLES  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supply_ok,
  input  logic                tick,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                cal_range,
  input  logic                rate_hi,
  input  logic                rate_lo,
  output logic                cal_pulse,
  output logic                rev_flag
);
  import cfa_pkg::*;

  logic [2:0]           mode;
  logic [3:0]           shift_w;
  logic                 fast_w, fire_w, fire_neg_w, light_w, hf_active_w, clear_w;
  logic [BASE_LOG2-1:0] acc_w;
  logic [BASE_LOG2:0]   thr_w;

  assign mode    = {cal_range, rate_hi, rate_lo};
  assign shift_w = rate_shift(mode);
  assign fast_w  = is_fast(mode);
  assign clear_w = !supply_ok;

  cfa_accum #(
    .SAMPLE_W(SAMPLE_W), .BASE_LOG2(BASE_LOG2), .NOLOAD_MIN(NOLOAD_MIN)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(clear_w), .valid(sample_valid),
    .sample(sample), .shift(shift_w), .fire(fire_w), .fire_neg(fire_neg_w),
    .light(light_w), .acc_level(acc_w), .thr(thr_w)
  );

  cfa_shaper #(
    .NOM_TICKS(NOM_TICKS), .HF_CYCLES(HF_CYCLES)
  ) u_shaper (
    .clk(clk), .rst_n(rst_n), .clear(clear_w), .tick(tick), .fire(fire_w),
    .fire_neg(fire_neg_w), .fast_mode(fast_w), .pulse(cal_pulse),
    .rev(rev_flag), .hf_active(hf_active_w)
  );
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
  parameter int BASE_LOG2 = 20,
  parameter int HF_CYCLES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 supply_ok,
  input logic                 sample_valid,
  input logic                 cal_pulse,
  input logic                 rev_flag,
  input logic                 fire,
  input logic                 fire_neg,
  input logic                 light,
  input logic                 hf_active,
  input logic [BASE_LOG2-1:0] acc_level,
  input logic [BASE_LOG2:0]   thr
);
  localparam int RC_W = $clog2(HF_CYCLES + 1) + 1;
  logic [RC_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_cnt <= '0;
    else if (fire)                   run_cnt <= '0;
    else if (cal_pulse && hf_active) run_cnt <= run_cnt + 1'b1;
    else                             run_cnt <= '0;
  end

  assert_unpowered_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !cal_pulse);
  assert_rise_needs_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pulse) |-> $past(fire));
  assert_flag_only_on_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !fire) |=> $stable(rev_flag));
  assert_flag_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rev_flag == $past(fire_neg)));
  assert_remainder_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ({1'b0, acc_level} < $past(thr)));
  assert_noload_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && light) |-> !fire);
  assert_fast_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_pulse && hf_active) |-> (run_cnt < RC_W'(HF_CYCLES)));
endmodule

bind cal_pulse_gen cfa_checker #(.BASE_LOG2(BASE_LOG2), .HF_CYCLES(HF_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sample_valid(sample_valid),
  .cal_pulse(cal_pulse), .rev_flag(rev_flag), .fire(fire_w), .fire_neg(fire_neg_w),
  .light(light_w), .hf_active(hf_active_w), .acc_level(acc_w), .thr(thr_w)
);

// File: tb/tb_cal_pulse_gen.sv
module tb_cal_pulse_gen;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0, supply_ok = 0, tick = 0, sample_valid = 0;
  logic [SW-1:0] sample = '0;
  logic cal_range = 0, rate_hi = 0, rate_lo = 0;
  logic cal_pulse, rev_flag;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  cal_pulse_gen #(.SAMPLE_W(SW), .BASE_LOG2(12), .NOLOAD_MIN(2),
                  .NOM_TICKS(4), .HF_CYCLES(5)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
    .sample_valid(sample_valid), .sample(sample), .cal_range(cal_range),
    .rate_hi(rate_hi), .rate_lo(rate_lo), .cal_pulse(cal_pulse), .rev_flag(rev_flag));

  // Vector table: mode, sample value, samples expected until the first pulse.
  localparam int NV = 8;
  localparam int V_MODE [NV] = '{4, 0, 5, 1, 6, 2, 7, 3};
  localparam int V_VAL  [NV] = '{5, -10, 64, -50, 128, 100, -30, 2};
  localparam int V_N    [NV] = '{7, 7, 1, 3, 1, 3, 9, 1};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    {cal_range, rate_hi, rate_lo} = 3'(m);
  endtask

  task automatic power_blip();
    @(negedge clk); supply_ok = 0;
    @(negedge clk); supply_ok = 1;
  endtask

  task automatic step(input int val, input int nticks,
                      output bit fired, output bit rv, output int width);
    @(negedge clk); sample_valid = 1; sample = SW'(val);
    @(negedge clk); sample_valid = 0;
    fired = cal_pulse; rv = rev_flag; width = 0;
    for (int t = 1; t <= nticks; t++) begin
      tick = 1;
      @(negedge clk); tick = 0;
      if (width == 0 && fired && !cal_pulse) width = t;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit f, rv;
    int w, cnt;
    repeat (3) @(negedge clk);
    check("R11 pulse after reset", cal_pulse, 0);
    check("R11 flag after reset", rev_flag, 0);
    rst_n = 1; supply_ok = 1;

    // R1/R2/R9: table walk
    for (int i = 0; i < NV; i++) begin
      power_blip();
      set_mode(V_MODE[i]);
      cnt = 0; f = 0;
      for (int k = 1; k <= 40 && !f; k++) begin
        step(V_VAL[i], 10, f, rv, w);
        cnt = k;
      end
      check($sformatf("R1 R2 R5 vec%0d samples to pulse", i), cnt, V_N[i]);
      check($sformatf("R9 vec%0d flag", i), rv, (V_VAL[i] < 0) ? 1 : 0);
    end

    // R2: remainder carried, mode 100 thr 32, samples of 20 -> pulses at 2,4,5
    power_blip(); set_mode(4);
    begin
      int exp_f [5] = '{0, 1, 0, 1, 1};
      for (int k = 0; k < 5; k++) begin
        step(20, 10, f, rv, w);
        check($sformatf("R2 remainder sample%0d", k + 1), f, exp_f[k]);
      end
    end

    // R3: clamp in fast mode (thr 2, sample 7 keeps 1), then 128x needs 16 of 2
    power_blip(); set_mode(3);
    step(7, 10, f, rv, w);
    check("R3 fast fire", f, 1);
    set_mode(4); cnt = 0; f = 0;
    for (int k = 1; k <= 40 && !f; k++) begin step(2, 10, f, rv, w); cnt = k; end
    check("R3 samples after clamp", cnt, 16);

    // R4: no-load samples ignored
    power_blip(); set_mode(3); cnt = 0;
    for (int k = 0; k < 10; k++) begin step((k % 2) ? -1 : 1, 2, f, rv, w); cnt += f; end
    check("R4 no pulse below floor", cnt, 0);
    check("R4 flag unchanged", rev_flag, 0);

    // R6/R7: widths from previous interval, mode 101 fires every sample of 64
    power_blip(); set_mode(5);
    step(64, 6, f, rv, w);  check("R6 first pulse width", w, 4);
    step(64, 6, f, rv, w);  check("R7 half of 6", w, 3);
    step(64, 10, f, rv, w); check("R7 half of 6 again", w, 3);
    step(64, 7, f, rv, w);  check("R6 after long interval", w, 4);
    step(64, 5, f, rv, w);  check("R7 half of 7", w, 3);
    step(64, 10, f, rv, w); check("R7 half of 5", w, 2);

    // R8: fast mode fixed width in cycles
    power_blip(); set_mode(3);
    @(negedge clk); sample_valid = 1; sample = SW'(2);
    @(negedge clk); sample_valid = 0;
    cnt = 0;
    while (cal_pulse && cnt < 50) begin cnt++; @(negedge clk); end
    check("R8 fast width cycles", cnt, 5);

    // R9: flag only moves with a pulse
    power_blip(); set_mode(4);
    step(20, 10, f, rv, w);  check("R9 no fire flag", rv, 0);
    step(-20, 10, f, rv, w); check("R9 negative fire flag", rv, 1);
    step(20, 10, f, rv, w);  check("R9 held without fire", rv, 1);
    check("R9 no pulse on hold", f, 0);
    step(20, 10, f, rv, w);  check("R9 positive fire flag", rv, 0);

    // R10: supply low
    set_mode(5);
    @(negedge clk); supply_ok = 0;
    cnt = 0;
    for (int k = 0; k < 3; k++) begin step(64, 2, f, rv, w); cnt += f; end
    check("R10 no pulse unpowered", cnt, 0);
    supply_ok = 1;
    step(-64, 0, f, rv, w);
    check("R10 pulse before drop", f, 1);
    @(negedge clk); supply_ok = 0;
    @(negedge clk);
    check("R10 pulse forced low", cal_pulse, 0);
    check("R10 flag cleared", rev_flag, 0);
    supply_ok = 1;
    set_mode(4);
    step(20, 10, f, rv, w);
    check("R10 accumulator cleared", f, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule